// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a watchdog timer. A 24-bit down-counter is reloaded from a programmable reload value whenever the `refresh` input is high. If software fails to refresh it in time, the count reaches zero and the block reacts in one of two ways. In reset mode it drives a system reset request. In interrupt mode it sends a one-cycle interrupt request. If the time-out happens while `stop_mode` is high, the block also issues a wake pulse that begins stop-mode recovery.

The block sits on a byte-wide register bus with a write strobe, a read strobe, a 2-bit address and 8-bit data. Address 0 is the control byte. Addresses 1, 2 and 3 hold reload bits 23:16, 15:8 and 7:0. The reload value is protected by a keyed sequence. First 55h is written to the control address, then AAh. The three reload bytes must then follow in the order upper, high, low, with no other write in between. The new 24-bit value takes effect as a whole, and only when the low byte is written.

The unlock controller has five states:
- `UL_LOCKED`
- `UL_KEY1_SEEN`
- `UL_OPEN_UPPER`
- `UL_OPEN_HIGH`
- `UL_OPEN_LOW`

Its transitions are as follows:
- key-A write: `UL_LOCKED` moves to `UL_KEY1_SEEN`.
- key-B write: `UL_KEY1_SEEN` moves to `UL_OPEN_UPPER`.
- upper write: `UL_OPEN_UPPER` moves to `UL_OPEN_HIGH`.
- high write: `UL_OPEN_HIGH` moves to `UL_OPEN_LOW`.
- commit: a low write in `UL_OPEN_LOW` returns the controller to `UL_LOCKED`.
- abort: any other write returns the controller to `UL_LOCKED` from any state.

The reset-output machine has two states, `RS_IDLE` and `RS_DRIVE`. It moves through these transitions:
- trigger: `RS_IDLE` moves to `RS_DRIVE` on a reset-mode time-out outside stop mode.
- retrigger: a further such time-out in `RS_DRIVE` restarts the hold.
- expire: `RS_DRIVE` returns to `RS_IDLE` when the hold count is used up.

Top module: `wdog_keyed`

## Requirements
- R1: After `rst_n` is released, each of the three reload bytes reads FFh. The control byte reads 00h, which means reset mode with both flags clear. The unlock controller is locked.
- R2: Writing 55h and then AAh to address 0 opens the reload registers. A control write of 55h or AAh never changes any control bit.
- R3: Once the reload registers are open, the bytes must be written in this order: address 1 (bits 23:16), then address 2 (bits 15:8), then address 3 (bits 7:0). The reload value changes as a whole on the address-3 write.
- R4: The sequence is aborted by any write that is not the next expected one: a wrong value, a wrong address or a write out of order. The controller then returns to locked and the reload value keeps its old contents. Reload writes made while locked are ignored.
- R5: A high `refresh` loads the counter from the reload value. Otherwise the counter decrements each cycle. A cycle with count zero is a time-out, and the counter then reloads.
- R6: Bit 0 of the control byte selects interrupt mode when set. In interrupt mode, `irq_pulse` is high for exactly one cycle. With reload N, that cycle starts at the (N+1)-th clock edge after the last refresh edge.
- R7: In reset mode with `stop_mode` low, a time-out raises `sys_reset` for exactly 4 cycles, starting at the same edge as in R6. It also sets the status flag, which is control bit 7.
- R8: A time-out with `stop_mode` high gives a one-cycle `stop_wake` pulse. It sets the status flag (bit 7) and the stop flag (bit 6) and never raises `sys_reset`. In interrupt mode it also gives `irq_pulse`.
- R9: A read of address 0 returns {status, stop, 00000b, mode}. Both flags clear at the following edge, but a time-out at that same edge sets them instead.
- R10: A control write of any value other than 55h or AAh loads the mode from data bit 0 and aborts any unlock sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 upper, 2 high, 3 low) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_re` is high, 00h otherwise |
| refresh | input | 1 | Reload the counter from the reload value |
| stop_mode | input | 1 | The system is in stop mode |
| irq_pulse | output | 1 | One-cycle interrupt request on time-out in interrupt mode |
| stop_wake | output | 1 | One-cycle stop-mode recovery request on time-out in stop mode |
| sys_reset | output | 1 | System reset request, held for 4 cycles |

## Verification
The assertions check the following on every cycle:
- the reload value changes only on a commit from `UL_OPEN_LOW`;
- a key write leaves the mode untouched;
- the counter steps down by exactly one when it is not refreshed;
- `irq_pulse`, `stop_wake` and the rising edge of `sys_reset` appear only after the matching mode and stop-mode state;
- a flag read with no time-out at the same edge clears both flags.

Some behaviour only the bench's scenarios can show. One such scenario is the exact cycle of each time-out counted from a refresh. Another is the 4-cycle length of the reset hold. A third is whether random sequences of broken and complete unlock writes leave the reload value exactly where the required order predicts.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int RELOAD_W = 24;
    localparam int BYTE_W   = 8;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_UPPER = 2'd1;
    localparam logic [1:0] ADDR_HIGH  = 2'd2;
    localparam logic [1:0] ADDR_LOW   = 2'd3;

    localparam int CTRL_MODE_BIT   = 0;
    localparam int CTRL_STOP_BIT   = 6;
    localparam int CTRL_STATUS_BIT = 7;

    typedef enum logic [2:0] {
        UL_LOCKED,
        UL_KEY1_SEEN,
        UL_OPEN_UPPER,
        UL_OPEN_HIGH,
        UL_OPEN_LOW
    } unlock_state_t;

    typedef enum logic {
        RS_IDLE,
        RS_DRIVE
    } rst_state_t;

endpackage

// File: rtl/wdk_unlock.sv
module wdk_unlock
    import wdk_pkg::*;
#(
    parameter logic [BYTE_W-1:0]   KEY_A       = 8'h55,
    parameter logic [BYTE_W-1:0]   KEY_B       = 8'hAA,
    parameter logic [RELOAD_W-1:0] RELOAD_INIT = 24'hFFFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [RELOAD_W-1:0] reload_q
);

    unlock_state_t st_q, st_n;
    logic [BYTE_W-1:0] stage_upper_q, stage_high_q;
    logic              is_ctrl;
    logic              commit;

    assign is_ctrl = (wr_addr == ADDR_CTRL);
    assign commit  = wr_en && (st_q == UL_OPEN_LOW) && (wr_addr == ADDR_LOW);

    // next state: every write leaves the current state; only the expected one advances
    always_comb begin
        st_n = st_q;
        if (wr_en) begin
            st_n = UL_LOCKED;
            unique case (st_q)
                UL_LOCKED:     if (is_ctrl && wr_data == KEY_A)  st_n = UL_KEY1_SEEN;
                UL_KEY1_SEEN:  if (is_ctrl && wr_data == KEY_B)  st_n = UL_OPEN_UPPER;
                UL_OPEN_UPPER: if (wr_addr == ADDR_UPPER)        st_n = UL_OPEN_HIGH;
                UL_OPEN_HIGH:  if (wr_addr == ADDR_HIGH)         st_n = UL_OPEN_LOW;
                UL_OPEN_LOW:   st_n = UL_LOCKED;
                default:       st_n = UL_LOCKED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UL_LOCKED;
        else        st_q <= st_n;
    end

    // staging and commit outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_upper_q <= RELOAD_INIT[23:16];
            stage_high_q  <= RELOAD_INIT[15:8];
            reload_q      <= RELOAD_INIT;
        end else begin
            if (wr_en && st_q == UL_OPEN_UPPER && wr_addr == ADDR_UPPER)
                stage_upper_q <= wr_data;
            if (wr_en && st_q == UL_OPEN_HIGH && wr_addr == ADDR_HIGH)
                stage_high_q <= wr_data;
            if (commit)
                reload_q <= {stage_upper_q, stage_high_q, wr_data};
        end
    end

    // R3 / R4: the reload value only ever moves on a low-byte write made from the last open state
    a_r4_commit_only_from_open_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q != $past(reload_q)) |-> ($past(st_q) == UL_OPEN_LOW && $past(wr_en)))
        else $error("reload changed outside commit");

    // R4: any write leaves the open states
    a_r4_write_leaves_open_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q == UL_OPEN_LOW) |=> (st_q == UL_LOCKED))
        else $error("unlock not relocked after low write");

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter logic [RELOAD_W-1:0] RELOAD_INIT = 24'hFFFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refresh,
    input  logic [RELOAD_W-1:0] reload,
    output logic                timeout
);

    logic [RELOAD_W-1:0] cnt_q;

    assign timeout = !refresh && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= RELOAD_INIT;
        else if (refresh)        cnt_q <= reload;
        else if (cnt_q == '0)    cnt_q <= reload;
        else                     cnt_q <= cnt_q - 1'b1;
    end

    // R5: an unrefreshed nonzero count steps down by one
    a_r5_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("counter did not decrement");

    // R5: a refresh loads the reload value
    a_r5_refresh_loads: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (cnt_q == $past(reload)))
        else $error("refresh did not load counter");

endmodule

// File: rtl/wdk_event.sv
module wdk_event
    import wdk_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic stop_mode,
    input  logic mode_irq,
    input  logic flag_clr,
    output logic irq_pulse,
    output logic stop_wake,
    output logic sys_reset,
    output logic status_flag,
    output logic stop_flag
);

    localparam int HOLD_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;

    rst_state_t        rs_q, rs_n;
    logic [HOLD_W-1:0] hold_q, hold_n;
    logic              trig;

    assign trig = timeout && !mode_irq && !stop_mode;

    // reset hold machine: next state
    always_comb begin
        rs_n   = rs_q;
        hold_n = hold_q;
        unique case (rs_q)
            RS_IDLE: begin
                if (trig) begin
                    rs_n   = RS_DRIVE;
                    hold_n = HOLD_W'(RST_HOLD - 1);
                end
            end
            RS_DRIVE: begin
                if (trig)                hold_n = HOLD_W'(RST_HOLD - 1);
                else if (hold_q == '0)   rs_n   = RS_IDLE;
                else                     hold_n = hold_q - 1'b1;
            end
            default: rs_n = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q   <= RS_IDLE;
            hold_q <= '0;
        end else begin
            rs_q   <= rs_n;
            hold_q <= hold_n;
        end
    end

    assign sys_reset = (rs_q == RS_DRIVE);

    // pulse and flag outputs; a set at the same edge wins over a read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse   <= 1'b0;
            stop_wake   <= 1'b0;
            status_flag <= 1'b0;
            stop_flag   <= 1'b0;
        end else begin
            irq_pulse <= timeout && mode_irq;
            stop_wake <= timeout && stop_mode;
            if (timeout)        status_flag <= 1'b1;
            else if (flag_clr)  status_flag <= 1'b0;
            if (timeout && stop_mode) stop_flag <= 1'b1;
            else if (flag_clr)        stop_flag <= 1'b0;
        end
    end

    // R8: the stop flag only rises after a stop-mode cycle
    a_r8_stop_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> $past(stop_mode))
        else $error("stop flag set outside stop mode");

    // R7: the reset output never drops while a hold count remains
    a_r7_hold_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset && hold_q != '0) |=> sys_reset)
        else $error("reset hold cut short");

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter logic [BYTE_W-1:0]   KEY_A       = 8'h55,
    parameter logic [BYTE_W-1:0]   KEY_B       = 8'hAA,
    parameter logic [RELOAD_W-1:0] RELOAD_INIT = 24'hFFFFFF,
    parameter int                  RST_HOLD    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              refresh,
    input  logic              stop_mode,
    output logic              irq_pulse,
    output logic              stop_wake,
    output logic              sys_reset
);

    logic [RELOAD_W-1:0] reload;
    logic                timeout;
    logic                mode_q;
    logic                status_flag, stop_flag;
    logic                ctrl_wr, key_value, flag_clr;

    assign ctrl_wr   = bus_we && (bus_addr == ADDR_CTRL);
    assign key_value = (bus_wdata == KEY_A) || (bus_wdata == KEY_B);
    assign flag_clr  = bus_re && (bus_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      mode_q <= 1'b0;
        else if (ctrl_wr && !key_value)  mode_q <= bus_wdata[CTRL_MODE_BIT];
    end

    wdk_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B), .RELOAD_INIT(RELOAD_INIT)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .reload_q (reload)
    );

    wdk_counter #(.RELOAD_INIT(RELOAD_INIT)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh),
        .reload  (reload),
        .timeout (timeout)
    );

    wdk_event #(.RST_HOLD(RST_HOLD)) u_event (
        .clk         (clk),
        .rst_n       (rst_n),
        .timeout     (timeout),
        .stop_mode   (stop_mode),
        .mode_irq    (mode_q),
        .flag_clr    (flag_clr),
        .irq_pulse   (irq_pulse),
        .stop_wake   (stop_wake),
        .sys_reset   (sys_reset),
        .status_flag (status_flag),
        .stop_flag   (stop_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (bus_addr)
                ADDR_CTRL: begin
                    bus_rdata[CTRL_STATUS_BIT] = status_flag;
                    bus_rdata[CTRL_STOP_BIT]   = stop_flag;
                    bus_rdata[CTRL_MODE_BIT]   = mode_q;
                end
                ADDR_UPPER: bus_rdata = reload[23:16];
                ADDR_HIGH:  bus_rdata = reload[15:8];
                ADDR_LOW:   bus_rdata = reload[7:0];
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R2: key writes leave the control byte alone
    a_r2_key_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && key_value) |=> $stable(mode_q))
        else $error("key write changed mode");

    // R6: an interrupt request only follows interrupt mode
    a_r6_irq_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(mode_q))
        else $error("irq outside interrupt mode");

    // R7 / R8: a reset starts only in reset mode outside stop mode
    a_r7_reset_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset) |-> $past(!mode_q && !stop_mode))
        else $error("reset raised in wrong mode");

    // R8: wake requests only come from stop mode
    a_r8_wake_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wake |-> $past(stop_mode))
        else $error("wake outside stop mode");

    // R9: a control read with no time-out clears both flags
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !timeout) |=> (!status_flag && !stop_flag))
        else $error("flags survived read");

endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       refresh = 1'b0, stop_mode = 1'b0;
    logic       irq_pulse, stop_wake, sys_reset;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench model of the keyed sequence
    int         m_st = 0;            // 0 locked, 1 key1, 2 open upper, 3 open high, 4 open low
    logic [7:0] m_up = 8'hFF, m_hi = 8'hFF;
    logic [23:0] m_reload = 24'hFFFFFF;
    logic       m_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_keyed uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .refresh(refresh), .stop_mode(stop_mode), .irq_pulse(irq_pulse),
        .stop_wake(stop_wake), .sys_reset(sys_reset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ctrl_byte(input logic st, input logic sp, input logic md);
        return {st, sp, 5'b00000, md};
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0 && d != 8'h55 && d != 8'hAA) m_mode = d[0];
        case (m_st)
            0: m_st = (a == 2'd0 && d == 8'h55) ? 1 : 0;
            1: m_st = (a == 2'd0 && d == 8'hAA) ? 2 : 0;
            2: if (a == 2'd1) begin m_up = d; m_st = 3; end else m_st = 0;
            3: if (a == 2'd2) begin m_hi = d; m_st = 4; end else m_st = 0;
            default: begin
                if (a == 2'd3) m_reload = {m_up, m_hi, d};
                m_st = 0;
            end
        endcase
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic check_reload(input string req);
        logic [7:0] v;
        do_rd(2'd1, v); check(req, v, m_reload[23:16]);
        do_rd(2'd2, v); check(req, v, m_reload[15:8]);
        do_rd(2'd3, v); check(req, v, m_reload[7:0]);
    endtask

    task automatic load_reload(input logic [23:0] val);
        do_wr(2'd0, 8'h55); do_wr(2'd0, 8'hAA);
        do_wr(2'd1, val[23:16]); do_wr(2'd2, val[15:8]); do_wr(2'd3, val[7:0]);
    endtask

    // one time-out window after a refresh: reload n, mode irqm, stop flag stp
    task automatic run_tmo(input int n, input logic irqm, input logic stp);
        logic [7:0] v;
        refresh = 1'b1;
        stop_mode = stp;
        do_wr(2'd0, {7'd0, irqm});
        load_reload(24'(n));
        do_rd(2'd0, v);
        check("R2 key writes keep mode", {24'd0, v[0]}, {31'd0, irqm});
        @(negedge clk);
        refresh = 1'b0;
        for (int i = 1; i <= n + 6; i++) begin
            @(negedge clk);
            check("R6 irq_pulse", irq_pulse, (i == n + 1) && irqm);
            check("R8 stop_wake", stop_wake, (i == n + 1) && stp);
            check("R7 sys_reset", sys_reset, !irqm && !stp && i >= n + 1 && i <= n + 4);
        end
        refresh = 1'b1;
        do_rd(2'd0, v);
        check("R9 flags after timeout", v, ctrl_byte(1'b1, stp, irqm));
        do_rd(2'd0, v);
        check("R9 flags cleared by read", v, ctrl_byte(1'b0, 1'b0, irqm));
        refresh = 1'b0;
        stop_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_rd(2'd0, v); check("R1 control after reset", v, 8'h00);
        check_reload("R1 reload after reset");
        check("R1 sys_reset idle", sys_reset, 1'b0);

        // R4 writes while locked are ignored
        refresh = 1'b1;
        do_wr(2'd1, 8'h12); do_wr(2'd2, 8'h34); do_wr(2'd3, 8'h56);
        check_reload("R4 locked writes ignored");

        // R2/R3 full sequence
        load_reload(24'h123456);
        check_reload("R3 ordered load");

        // R4 directed breaks
        do_wr(2'd0, 8'h55); do_wr(2'd0, 8'hAA); do_wr(2'd2, 8'h99);
        check_reload("R4 out-of-order byte");
        do_wr(2'd0, 8'h55); do_wr(2'd0, 8'hAA); do_wr(2'd1, 8'h77); do_wr(2'd0, 8'h01);
        do_wr(2'd2, 8'h88); do_wr(2'd3, 8'h99);
        check_reload("R4 control write in middle");
        do_rd(2'd0, v); check("R10 non-key write sets mode", {24'd0, v}, {24'd0, 8'h01});
        do_wr(2'd0, 8'h55); do_wr(2'd0, 8'h55); do_wr(2'd0, 8'hAA);
        do_wr(2'd1, 8'h01); do_wr(2'd2, 8'h02); do_wr(2'd3, 8'h03);
        check_reload("R4 repeated key A");
        do_wr(2'd0, 8'h00);
        refresh = 1'b0;

        // R5-R9 directed windows
        run_tmo(6, 1'b1, 1'b0);
        run_tmo(6, 1'b0, 1'b0);
        run_tmo(7, 1'b0, 1'b1);
        run_tmo(8, 1'b1, 1'b1);

        // R2/R3/R4 random keyed sequences against the model
        refresh = 1'b1;
        for (int it = 0; it < 150; it++) begin
            int kind;
            kind = $urandom_range(0, 2);
            if (kind == 2) begin
                int len;
                len = $urandom_range(1, 6);
                for (int k = 0; k < len; k++) begin
                    logic [1:0] a;
                    logic [7:0] d;
                    int pick;
                    a = 2'($urandom_range(0, 3));
                    pick = $urandom_range(0, 2);
                    d = (pick == 0) ? 8'h55 : (pick == 1) ? 8'hAA : 8'($urandom);
                    do_wr(a, d);
                end
            end else begin
                logic [1:0] sa [5];
                logic [7:0] sd [5];
                sa[0] = 2'd0; sd[0] = 8'h55;
                sa[1] = 2'd0; sd[1] = 8'hAA;
                sa[2] = 2'd1; sd[2] = 8'($urandom);
                sa[3] = 2'd2; sd[3] = 8'($urandom);
                sa[4] = 2'd3; sd[4] = 8'($urandom);
                if (kind == 1) begin
                    int pos;
                    pos = $urandom_range(0, 4);
                    sa[pos] = 2'($urandom_range(0, 3));
                    sd[pos] = 8'($urandom);
                end
                for (int k = 0; k < 5; k++) do_wr(sa[k], sd[k]);
            end
            check_reload("R4 random sequence");
        end
        refresh = 1'b0;

        // R5-R8 random time-out windows
        for (int it = 0; it < 12; it++) begin
            run_tmo($urandom_range(6, 30), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule